// File: doc/BRIEF.md
# Region Permission Checker with Machine-Mode Lockdown

This block decides, for every memory access, whether the access may go ahead. It keeps a small table of address rules. Each rule stores read, write and execute permission bits, a lock bit and a range mode. The range is either top-of-range (TOR) or a naturally aligned power-of-two window (NAPOT). An access request gives a byte address, an access type and a privilege mode, and the block answers with a single allow bit. The answer is purely combinational. Rules and the control bits change only through one registered write port, and that port rejects encodings that are reserved or forbidden, so they are never stored.

A control register holds two sticky bits. The first is lockdown. While lockdown is clear, the rules behave in the classic way: machine mode has full access to unlocked regions and is bound by the permission bits of locked ones. Once lockdown is set, the same four bits are read differently. The lock bit now says whether the rule belongs to machine mode or to user/supervisor mode. The read-clear/write-set pattern, which is reserved in the classic scheme, now marks a region shared by both sides. No rule bit is added for any of this. The second control bit allows shared regions that are executable. Without it, only non-executable shared rules can be installed.

Top module: `pmp_guard`

## Requirements
- R1: After reset every rule is off and both control bits are clear, so machine mode is allowed every access and user/supervisor mode (mode codes 0 and 1; code 3 is machine) is denied every access.
- R2: The lowest-numbered rule whose range holds the address decides the answer. When no rule holds the address, machine mode is allowed and the other modes are denied.
- R3: The range mode sits in config bits 4:3, with 1 for TOR, 3 for NAPOT, and 0 or 2 for off. A TOR rule covers word addresses from the previous rule's address field (zero for rule 0) up to, but not including, its own field. A NAPOT rule with t trailing ones in its address field covers 2^(t+3) bytes, aligned to that size.
- R4: With lockdown clear, user/supervisor access follows the rule's R (bit 0), W (bit 1) and X (bit 2) bits. Machine mode has full access when the lock bit (bit 7) is clear and follows R/W/X when it is set. Access types are 0 read, 1 write and 2 execute.
- R5: With lockdown clear, a config write with R=0 and W=1 leaves the rule unchanged.
- R6: With lockdown set, a non-shared rule with lock clear grants machine mode nothing, even if it carried execute permission before lockdown, and grants user/supervisor mode its R/W/X. With lock set, it grants machine mode its R/W/X and grants user/supervisor mode nothing.
- R7: With lockdown set, a rule with R=0 and W=1 is shared. With L=0 and X=0, both sides may read and write. With L=0 and X=1, machine mode may read and write and the other modes may only read. With L=1 and X=0, both sides may only execute. With L=1 and X=1, machine mode may read and execute and the other modes may only execute.
- R8: With lockdown set and the shared-execute enable clear, a config write of a shared rule with L=1 leaves the rule unchanged.
- R9: Writing the control register with bit 0 set sets lockdown, and with bit 1 set sets the shared-execute enable. Neither bit is cleared by any write; only reset clears them.
- R10: A rule whose lock bit is set ignores every later write to its config and to its address field until reset.
- R11: With lockdown set, no stored rule lets user/supervisor mode write a location that machine mode may execute.
- R12: A config, address or control write presented on the port changes the decision only after the next rising clock edge. The decision follows request inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the configuration port |
| wrKind | input | 2 | Write target: 0 rule config, 1 rule address, 2 control, 3 none |
| wrIdx | input | IDX_W | Rule index for config and address writes |
| wrData | input | ADDR_W-2 | Write data; config uses bits 7:0, control uses bits 1:0 |
| reqAddr | input | ADDR_W | Byte address of the access |
| reqType | input | 2 | Access type: 0 read, 1 write, 2 execute |
| reqMode | input | 2 | Privilege: 0 user, 1 supervisor, 3 machine |
| allow | output | 1 | High when the access is permitted |

## Verification
A stored rule that is wrong, such as a reserved encoding that got past the filter or a locked rule that accepted a rewrite, cannot be read back. It shows only as a wrong allow bit, and it shows on the first request that falls in that rule's range after the write edge. The bench therefore probes each rule's window in all three modes and all three access types right after every write, and it probes a known address outside the window as well. A control bit that fails to stick changes the machine-mode answer for an unlocked rule on the very next request, so each attempt to clear a control bit is followed directly by such a probe.

// File: rtl/pmp_guard_pkg.sv
package pmp_guard_pkg;

  typedef enum logic [1:0] {
    AM_OFF   = 2'd0,
    AM_TOR   = 2'd1,
    AM_RSVD  = 2'd2,
    AM_NAPOT = 2'd3
  } amode_e;

  typedef enum logic [1:0] {
    WK_CFG  = 2'd0,
    WK_ADDR = 2'd1,
    WK_CTRL = 2'd2,
    WK_NONE = 2'd3
  } wkind_e;

  localparam logic [1:0] MODE_MACHINE = 2'd3;
  localparam logic [1:0] ACC_READ     = 2'd0;
  localparam logic [1:0] ACC_WRITE    = 2'd1;
  localparam logic [1:0] ACC_EXEC     = 2'd2;

  typedef struct packed {
    logic   lock;
    amode_e amode;
    logic   x;
    logic   w;
    logic   r;
  } rule_cfg_t;

  // per-rule strobes from control to datapath
  typedef struct packed {
    logic cfgWe;
    logic addrWe;
  } rule_strobe_t;

  function automatic rule_cfg_t unpackCfg(input logic [7:0] b);
    rule_cfg_t c;
    c.r     = b[0];
    c.w     = b[1];
    c.x     = b[2];
    c.amode = amode_e'(b[4:3]);
    c.lock  = b[7];
    return c;
  endfunction

  function automatic logic isShared(input rule_cfg_t c);
    return !c.r && c.w;
  endfunction

  // permission decode of one matched rule
  function automatic logic ruleGrants(input rule_cfg_t c, input logic lockdown,
                                      input logic isMachine, input logic [1:0] acc);
    logic isRd, isWr, isEx, own;
    isRd = (acc == ACC_READ);
    isWr = (acc == ACC_WRITE);
    isEx = !isRd && !isWr;
    own  = (isRd && c.r) || (isWr && c.w) || (isEx && c.x);
    if (!lockdown)
      return isMachine ? (c.lock ? own : 1'b1) : own;
    if (!isShared(c))
      return isMachine ? (c.lock && own) : (!c.lock && own);
    unique case ({c.lock, c.x})
      2'b00:   return !isEx;
      2'b01:   return isMachine ? !isEx : isRd;
      2'b10:   return isEx;
      default: return isMachine ? !isWr : isEx;
    endcase
  endfunction

endpackage

// File: rtl/pmp_guard_ctrl.sv
module pmp_guard_ctrl
  import pmp_guard_pkg::*;
#(
  parameter int NUM_RULES = 4,
  parameter int IDX_W     = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [1:0]           wrKind,
  input  logic [IDX_W-1:0]     wrIdx,
  input  logic [7:0]           wrCfgByte,
  input  logic [NUM_RULES-1:0] ruleLocked,
  output rule_strobe_t         strobes [NUM_RULES],
  output logic                 lockdown,
  output logic                 sharedExecEn
);

  rule_cfg_t newCfg;
  logic      reservedLegacy;
  logic      blockedSharedExec;
  logic      cfgLegal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockdown     <= 1'b0;
      sharedExecEn <= 1'b0;
    end else if (wrEn && wrKind == WK_CTRL) begin
      if (wrCfgByte[0]) lockdown     <= 1'b1;
      if (wrCfgByte[1]) sharedExecEn <= 1'b1;
    end
  end

  always_comb begin
    newCfg            = unpackCfg(wrCfgByte);
    reservedLegacy    = !lockdown && isShared(newCfg);
    blockedSharedExec = lockdown && !sharedExecEn && isShared(newCfg) && newCfg.lock;
    cfgLegal          = !reservedLegacy && !blockedSharedExec;
  end

  for (genvar i = 0; i < NUM_RULES; i++) begin : g_strobe
    logic sel;
    assign sel               = wrEn && (wrIdx == IDX_W'(i)) && !ruleLocked[i];
    assign strobes[i].cfgWe  = sel && (wrKind == WK_CFG) && cfgLegal;
    assign strobes[i].addrWe = sel && (wrKind == WK_ADDR);
  end

  p_lockdown_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    lockdown |=> lockdown);
  p_shexec_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    sharedExecEn |=> sharedExecEn);

endmodule

// File: rtl/pmp_guard_data.sv
module pmp_guard_data
  import pmp_guard_pkg::*;
#(
  parameter int NUM_RULES = 4,
  parameter int ADDR_W    = 32,
  localparam int WORD_W   = ADDR_W - 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  rule_strobe_t         strobes [NUM_RULES],
  input  logic [WORD_W-1:0]    wrData,
  input  logic                 lockdown,
  input  logic                 sharedExecEn,
  input  logic [WORD_W-1:0]    reqWord,
  input  logic [1:0]           reqType,
  input  logic [1:0]           reqMode,
  output logic [NUM_RULES-1:0] ruleLocked,
  output logic                 allow
);

  rule_cfg_t         ruleCfg  [NUM_RULES];
  logic [WORD_W-1:0] ruleAddr [NUM_RULES];
  logic [NUM_RULES-1:0] hit;
  logic [NUM_RULES-1:0] grant;
  logic isMachine;

  assign isMachine = (reqMode == MODE_MACHINE);

  for (genvar i = 0; i < NUM_RULES; i++) begin : g_rule
    logic [WORD_W-1:0] lowBound;
    logic [WORD_W-1:0] napotMask;
    logic torHit, napotHit;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ruleCfg[i]  <= '0;
        ruleAddr[i] <= '0;
      end else begin
        if (strobes[i].cfgWe)  ruleCfg[i]  <= unpackCfg(wrData[7:0]);
        if (strobes[i].addrWe) ruleAddr[i] <= wrData;
      end
    end

    if (i == 0) begin : g_first
      assign lowBound = '0;
    end else begin : g_next
      assign lowBound = ruleAddr[i-1];
    end

    assign napotMask = ruleAddr[i] ^ (ruleAddr[i] + 1'b1);
    assign torHit    = (reqWord >= lowBound) && (reqWord < ruleAddr[i]);
    assign napotHit  = ((reqWord ^ ruleAddr[i]) & ~napotMask) == '0;
    assign hit[i]    = (ruleCfg[i].amode == AM_TOR)   ? torHit :
                       (ruleCfg[i].amode == AM_NAPOT) ? napotHit : 1'b0;
    assign grant[i]  = ruleGrants(ruleCfg[i], lockdown, isMachine, reqType);
    assign ruleLocked[i] = ruleCfg[i].lock;

    p_locked_frozen_r10: assert property (@(posedge clk) disable iff (!rstN)
      ruleCfg[i].lock |=> ($stable(ruleCfg[i]) && $stable(ruleAddr[i])));
    p_no_reserved_r5: assert property (@(posedge clk) disable iff (!rstN)
      !lockdown |-> !isShared(ruleCfg[i]));
    p_no_gated_exec_r8: assert property (@(posedge clk) disable iff (!rstN)
      (lockdown && !sharedExecEn) |-> !(isShared(ruleCfg[i]) && ruleCfg[i].lock));
    p_no_wx_cross_r11: assert property (@(posedge clk) disable iff (!rstN)
      lockdown |-> !(ruleGrants(ruleCfg[i], 1'b1, 1'b0, ACC_WRITE) &&
                     ruleGrants(ruleCfg[i], 1'b1, 1'b1, ACC_EXEC)));
  end

  // lowest index wins: scan downward so the last assignment is the lowest hit
  always_comb begin
    allow = isMachine;
    for (int i = NUM_RULES - 1; i >= 0; i--) begin
      if (hit[i]) allow = grant[i];
    end
  end

  p_nomatch_r2: assert property (@(posedge clk) disable iff (!rstN)
    (hit == '0) |-> (allow == isMachine));

endmodule

// File: rtl/pmp_guard.sv
module pmp_guard
  import pmp_guard_pkg::*;
#(
  parameter int NUM_RULES = 4,
  parameter int ADDR_W    = 32,
  localparam int IDX_W    = (NUM_RULES > 1) ? $clog2(NUM_RULES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrKind,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [ADDR_W-3:0] wrData,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqType,
  input  logic [1:0]        reqMode,
  output logic              allow
);

  rule_strobe_t         strobes [NUM_RULES];
  logic [NUM_RULES-1:0] ruleLocked;
  logic                 lockdown;
  logic                 sharedExecEn;

  pmp_guard_ctrl #(.NUM_RULES(NUM_RULES), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrKind(wrKind), .wrIdx(wrIdx),
    .wrCfgByte(wrData[7:0]), .ruleLocked(ruleLocked), .strobes(strobes),
    .lockdown(lockdown), .sharedExecEn(sharedExecEn)
  );

  pmp_guard_data #(.NUM_RULES(NUM_RULES), .ADDR_W(ADDR_W)) u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData),
    .lockdown(lockdown), .sharedExecEn(sharedExecEn),
    .reqWord(reqAddr[ADDR_W-1:2]), .reqType(reqType), .reqMode(reqMode),
    .ruleLocked(ruleLocked), .allow(allow)
  );

endmodule

// File: tb/sim_pmp_guard.sv
module sim_pmp_guard;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrKind = 2'd3;
  logic [1:0]  wrIdx = '0;
  logic [29:0] wrData = '0;
  logic [31:0] reqAddr = '0;
  logic [1:0]  reqType = '0;
  logic [1:0]  reqMode = '0;
  logic        allow;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pmp_guard u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrKind(wrKind), .wrIdx(wrIdx),
    .wrData(wrData), .reqAddr(reqAddr), .reqType(reqType), .reqMode(reqMode),
    .allow(allow)
  );

  localparam logic [29:0] WIN_FIELD = 30'h41F;   // bytes 0x1000..0x10FF
  localparam logic [31:0] WIN_ADDR  = 32'h1040;

  function automatic logic [7:0] cfgByte(bit l, logic [1:0] am, bit x, bit w, bit r);
    return {l, 2'b00, am, x, w, r};
  endfunction

  // reference decision of one matched rule, from the requirement tables
  function automatic bit refGrant(bit ld, bit l, bit r, bit w, bit x, bit m, int t);
    bit own;
    own = (t == 0) ? r : (t == 1) ? w : x;
    if (!ld) return m ? (l ? own : 1'b1) : own;
    if (!(!r && w)) return m ? (l && own) : (!l && own);
    if (!l && !x) return t != 2;
    if (!l && x)  return m ? (t != 2) : (t == 0);
    if (l && !x)  return t == 2;
    return m ? (t != 1) : (t == 2);
  endfunction

  task automatic doReset();
    @(negedge clk);
    wrEn = 0; rstN = 0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1;
  endtask

  task automatic doWrite(logic [1:0] kind, int idx, logic [29:0] data);
    @(negedge clk);
    wrEn = 1; wrKind = kind; wrIdx = idx[1:0]; wrData = data;
    @(negedge clk);
    wrEn = 0; wrKind = 2'd3;
  endtask

  task automatic probe(logic [31:0] a, int t, int m, bit exp, string tag);
    reqAddr = a; reqType = t[1:0]; reqMode = m[1:0];
    #1;
    checks++;
    if (allow !== exp) begin
      errors++;
      $display("FAIL %s addr=%h type=%0d mode=%0d actual=%b expected=%b",
               tag, a, t, m, allow, exp);
    end
  endtask

  task automatic testReset();
    doReset();
    for (int m = 0; m < 4; m++) begin
      if (m == 2) continue;
      for (int t = 0; t < 3; t++) probe(32'h1234, t, m, m == 3, "R1");
    end
  endtask

  task automatic testPriority();
    doReset();
    doWrite(2'd1, 0, 30'h43);                      // 0x100..0x11F
    doWrite(2'd0, 0, cfgByte(0, 2'd3, 0, 0, 1));
    doWrite(2'd1, 1, 30'h7F);                      // 0x000..0x3FF
    doWrite(2'd0, 1, cfgByte(0, 2'd3, 1, 1, 1));
    probe(32'h110, 1, 0, 0, "R2");
    probe(32'h110, 0, 0, 1, "R2");
    probe(32'h200, 1, 0, 1, "R2");
    probe(32'h200, 2, 1, 1, "R2");
    probe(32'h400, 0, 0, 0, "R2");
    probe(32'h400, 0, 3, 1, "R2");
  endtask

  task automatic testRanges();
    doReset();
    doWrite(2'd1, 0, 30'h100);
    doWrite(2'd1, 1, 30'h200);
    doWrite(2'd0, 0, cfgByte(0, 2'd1, 0, 0, 1));
    doWrite(2'd0, 1, cfgByte(0, 2'd1, 0, 1, 1));
    probe(32'h0, 0, 0, 1, "R3");
    probe(32'h3FC, 1, 0, 0, "R3");
    probe(32'h400, 1, 0, 1, "R3");
    probe(32'h7FC, 1, 0, 1, "R3");
    probe(32'h800, 0, 0, 0, "R3");
    doReset();
    doWrite(2'd1, 0, 30'h43);
    doWrite(2'd0, 0, cfgByte(0, 2'd3, 0, 0, 1));
    probe(32'h100, 0, 0, 1, "R3");
    probe(32'h11C, 0, 0, 1, "R3");
    probe(32'h120, 0, 0, 0, "R3");
    probe(32'h0FC, 0, 0, 0, "R3");
    doWrite(2'd0, 0, cfgByte(0, 2'd2, 0, 0, 1));   // mode 2 acts as off
    probe(32'h100, 0, 0, 0, "R3");
  endtask

  task automatic testReservedLegacy();
    doReset();
    doWrite(2'd1, 0, WIN_FIELD);
    doWrite(2'd0, 0, cfgByte(0, 2'd3, 1, 1, 1));
    doWrite(2'd0, 0, cfgByte(0, 2'd3, 0, 1, 0));
    probe(WIN_ADDR, 2, 0, 1, "R5");
    probe(WIN_ADDR, 0, 1, 1, "R5");
  endtask

  task automatic testLockdownOwner();
    doReset();
    doWrite(2'd1, 0, WIN_FIELD);
    doWrite(2'd0, 0, cfgByte(0, 2'd3, 1, 0, 0));
    probe(WIN_ADDR, 2, 3, 1, "R4");
    doWrite(2'd2, 0, 30'h1);
    probe(WIN_ADDR, 2, 3, 0, "R6");
    probe(WIN_ADDR, 0, 3, 0, "R6");
    probe(WIN_ADDR, 2, 0, 1, "R6");
    doWrite(2'd2, 0, 30'h0);
    probe(WIN_ADDR, 2, 3, 0, "R9");
  endtask

  task automatic testSharedExecGate();
    doReset();
    doWrite(2'd2, 0, 30'h1);
    doWrite(2'd1, 0, WIN_FIELD);
    doWrite(2'd0, 0, cfgByte(1, 2'd3, 0, 1, 0));
    probe(WIN_ADDR, 2, 0, 0, "R8");
    probe(WIN_ADDR, 0, 3, 1, "R8");
    doWrite(2'd2, 0, 30'h2);
    doWrite(2'd2, 0, 30'h0);
    doWrite(2'd0, 0, cfgByte(1, 2'd3, 0, 1, 0));
    probe(WIN_ADDR, 2, 0, 1, "R9");
    probe(WIN_ADDR, 0, 0, 0, "R7");
    probe(WIN_ADDR, 0, 3, 0, "R7");
    doWrite(2'd1, 1, 30'h7F);
    doWrite(2'd0, 1, cfgByte(0, 2'd3, 0, 1, 0));
    probe(32'h200, 1, 0, 1, "R7");
    probe(32'h200, 2, 3, 0, "R7");
  endtask

  task automatic testLockedFrozen();
    doReset();
    doWrite(2'd1, 0, WIN_FIELD);
    doWrite(2'd0, 0, cfgByte(1, 2'd3, 0, 0, 1));
    probe(WIN_ADDR, 0, 0, 1, "R4");
    probe(WIN_ADDR, 1, 3, 0, "R4");
    doWrite(2'd0, 0, cfgByte(0, 2'd3, 1, 1, 1));
    probe(WIN_ADDR, 1, 0, 0, "R10");
    doWrite(2'd1, 0, 30'h7F);
    probe(32'h200, 0, 0, 0, "R10");
    probe(WIN_ADDR, 0, 0, 1, "R10");
  endtask

  task automatic testWriteTiming();
    doReset();
    doWrite(2'd1, 0, WIN_FIELD);
    @(negedge clk);
    wrEn = 1; wrKind = 2'd0; wrIdx = 0; wrData = cfgByte(0, 2'd3, 0, 0, 1);
    probe(WIN_ADDR, 0, 0, 0, "R12");
    @(negedge clk);
    wrEn = 0; wrKind = 2'd3;
    probe(WIN_ADDR, 0, 0, 1, "R12");
  endtask

  task automatic testExhaustive();
    for (int pass = 0; pass < 3; pass++) begin
      for (int code = 0; code < 16; code++) begin
        bit ld, sxe, l, r, w, x, stored, uw, mx;
        ld = (pass > 0); sxe = (pass == 2);
        r = code[0]; w = code[1]; x = code[2]; l = code[3];
        doReset();
        if (ld) doWrite(2'd2, 0, {28'd0, sxe, 1'b1});
        doWrite(2'd1, 0, WIN_FIELD);
        doWrite(2'd0, 0, cfgByte(l, 2'd3, x, w, r));
        stored = !(!ld && !r && w) && !(ld && !sxe && l && !r && w);
        for (int m = 0; m < 4; m++) begin
          if (m == 2) continue;
          for (int t = 0; t < 3; t++)
            probe(WIN_ADDR, t, m, stored ? refGrant(ld, l, r, w, x, m == 3, t) : (m == 3),
                  ld ? "R6/R7 table" : "R4 table");
        end
        reqAddr = WIN_ADDR; reqType = 2'd1; reqMode = 2'd0; #1; uw = allow;
        reqType = 2'd2; reqMode = 2'd3; #1; mx = allow;
        checks++;
        if (ld && uw && mx) begin
          errors++;
          $display("FAIL R11 code=%0d actual=user-write+machine-exec expected=not both", code);
        end
      end
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    testReset();
    testPriority();
    testRanges();
    testReservedLegacy();
    testLockdownOwner();
    testSharedExecGate();
    testLockedFrozen();
    testWriteTiming();
    testExhaustive();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule